// File: doc/BRIEF.md
# Halt-Driven Power-Mode Controller

This block is the low-power sequencer beside a small processor core. It owns two registers on the core's I/O port bus. The first is a write-only clock-speed control register whose bits 10:8 set how deep a sleep may go. The second is a readable interrupt-control register whose bit 14 is an arm flag. The block decodes a single halt opcode. When the core issues it, the block signals a one-step program-counter advance. It then chooses one of three reduced-power levels from the register contents at that instant and closes the matching clock enables.

Only the halt opcode can start a low-power period. An external interrupt ends it. After light or mid idle, the clocks come back on the next cycle. After deep sleep, the oscillator enable returns first, and both clock gates stay shut for a parameterised settling count. In every case a registered wake-pending pulse goes to the interrupt controller one cycle after the clocks restart.

All ports are plain control and status signals. None carries a data stream, so the block has no valid/ready handshake and no back-pressure: an I/O access or an instruction presented with its strobe is taken in the same cycle.

Top module: `pmc_idle_ctrl`

## Requirements
- R1: Only an instruction word equal to 17'h1FE20 (bits 16..0 = 1_1111_1110_0010_0000) presented with `instr_valid` while running is a halt. It raises `halt_step` in that same cycle and closes the core clock enable at the next edge. Any other word has no effect on the clock enables.
- R2: A write to I/O address 0x3D stores bits 10:8 of the write data as the sleep-depth field. A read of 0x3D always returns zero.
- R3: I/O address 0x38 holds a 16-bit interrupt-control value that reads back exactly as written. Bit 14 of that value is the arm flag.
- R4: If sleep-depth bit 10 is 0 at the halt, the block enters light idle: `core_clk_en`=0, `periph_clk_en`=1, `osc_en`=1.
- R5: If bit 10 is 1 and deep sleep is not selected (arm is 0, or bits 9:8 are nonzero), the block enters mid idle: `core_clk_en`=0, `periph_clk_en`=0, `osc_en`=1.
- R6: If bit 10 is 1, bits 9:8 are 00 and arm is 1 at the halt, the block enters deep sleep: all three enables are 0.
- R7: The mode is fixed by the register contents in the halt cycle and holds steady while halted. `ext_irq` while running has no effect.
- R8: In light or mid idle, `ext_irq` sampled at an edge turns all three enables back to 1 at that edge.
- R9: In deep sleep, `ext_irq` sampled at an edge sets `osc_en`=1 at that edge. Both clock enables then stay 0 for exactly SETTLE_CYC cycles before all enables return to 1.
- R10: `wake_pend` is high for exactly one cycle, in the second cycle with the clocks running after a wake, and is low at all other times.
- R11: Reset clears the sleep-depth field and the interrupt-control register, and leaves all three enables at 1 with `wake_pend` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data (combinational) |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 17 | Instruction opcode word |
| halt_step | output | 1 | Halt accepted; advance program counter by one |
| ext_irq | input | 1 | External interrupt (wake request) |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pend | output | 1 | One-cycle wake-pending pulse to interrupt controller |

## Verification
The hardest state to reach is the deep-sleep settling window. It needs a particular combination of a write-only field, which cannot be read back to confirm it, and the arm bit, followed by a halt and then an interrupt. The bench gets there by sweeping all eight depth-field values against both arm values. For each pair it computes the expected mode, then times the settle window and the wake pulse cycle by cycle, using a small SETTLE_CYC so every window is counted exactly.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_LIGHT = 2'd0,
    MODE_MID   = 2'd1,
    MODE_DEEP  = 2'd2
  } pmode_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } pstate_t;

  localparam int OPC_W = 17;
  localparam logic [OPC_W-1:0] HALT_OPC = 17'h1FE20;
endpackage

// File: rtl/pmc_io_regs.sv
module pmc_io_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] SPD_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] ICTL_ADDR = 8'h38,
  parameter int SPD_LO = 8,
  parameter int SPD_W = 3,
  parameter int ARM_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [SPD_W-1:0]  spd_bits,
  output logic              arm
);
  localparam int SPD_HI = SPD_LO + SPD_W - 1;

  logic [SPD_W-1:0]  spd_q;
  logic [DATA_W-1:0] ictl_q;
  logic              spd_sel, ictl_sel;

  assign spd_sel  = (io_addr == SPD_ADDR);
  assign ictl_sel = (io_addr == ICTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q  <= '0;
      ictl_q <= '0;
    end else if (io_wr) begin
      if (spd_sel)  spd_q  <= io_wdata[SPD_HI:SPD_LO];
      if (ictl_sel) ictl_q <= io_wdata;
    end
  end

  // The depth field has no read path: only the interrupt-control value is muxed out.
  always_comb begin
    io_rdata = '0;
    if (io_rd && ictl_sel) io_rdata = ictl_q;
  end

  assign spd_bits = spd_q;
  assign arm      = ictl_q[ARM_BIT];

  // R2
  spd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && spd_sel) |-> (io_rdata == '0));

  // R3
  ictl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && ictl_sel) |=> (arm == $past(io_wdata[ARM_BIT])));
endmodule

// File: rtl/pmc_mode_sel.sv
module pmc_mode_sel
  import pmc_pkg::*;
#(
  parameter int SPD_W = 3
) (
  input  logic [SPD_W-1:0] spd_bits,
  input  logic             arm,
  output pmode_t           mode
);
  localparam int ENA_BIT = SPD_W - 1;

  logic gate_periph, sub_zero;

  assign gate_periph = spd_bits[ENA_BIT];
  assign sub_zero    = (spd_bits[ENA_BIT-1:0] == '0);

  always_comb begin
    if (!gate_periph)          mode = MODE_LIGHT;
    else if (sub_zero && arm)  mode = MODE_DEEP;
    else                       mode = MODE_MID;
  end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt_hit,
  input  pmode_t sel_mode,
  input  logic   ext_irq,
  output logic   running,
  output logic   core_clk_en,
  output logic   periph_clk_en,
  output logic   osc_en,
  output logic   wake_pend
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  pstate_t          state_q, state_d;
  pmode_t           mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             resume, resume_q, wake_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (halt_hit) state_d = ST_SLEEP;
      ST_SLEEP:  if (ext_irq)  state_d = (mode_q == MODE_DEEP) ? ST_SETTLE : ST_RUN;
      ST_SETTLE: if (cnt_q == CNT_LAST) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  assign resume = (state_q != ST_RUN) && (state_d == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      mode_q   <= MODE_LIGHT;
      cnt_q    <= '0;
      resume_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume;
      wake_q   <= resume_q;
      if (state_q == ST_RUN && halt_hit) mode_q <= sel_mode;
      if (state_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
    end
  end

  assign running       = (state_q == ST_RUN);
  assign core_clk_en   = running;
  assign periph_clk_en = running || (state_q == ST_SLEEP && mode_q == MODE_LIGHT);
  assign osc_en        = !(state_q == ST_SLEEP && mode_q == MODE_DEEP);
  assign wake_pend     = wake_q;

  // R1
  halt_gates_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> !core_clk_en);

  // R10
  wake_after_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |=> wake_pend);

  // R10
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend |=> !wake_pend);

  // R9
  osc_before_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !core_clk_en);

  // R7
  irq_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !halt_hit) |=> core_clk_en);

  // R6
  osc_off_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!core_clk_en && !periph_clk_en));
endmodule

// File: rtl/pmc_idle_ctrl.sv
module pmc_idle_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              instr_valid,
  input  logic [OPC_W-1:0]  instr_word,
  output logic              halt_step,
  input  logic              ext_irq,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              osc_en,
  output logic              wake_pend
);
  localparam int SPD_W = 3;

  logic [SPD_W-1:0] spd_bits;
  logic             arm, running, halt_hit;
  pmode_t           sel_mode;

  pmc_io_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SPD_ADDR(ADDR_W'(8'h3D)), .ICTL_ADDR(ADDR_W'(8'h38)),
    .SPD_LO(8), .SPD_W(SPD_W), .ARM_BIT(14)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .spd_bits(spd_bits), .arm(arm)
  );

  pmc_mode_sel #(.SPD_W(SPD_W)) u_sel (
    .spd_bits(spd_bits), .arm(arm), .mode(sel_mode)
  );

  assign halt_hit  = running && instr_valid && (instr_word == HALT_OPC);
  assign halt_step = halt_hit;

  pmc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt_hit(halt_hit), .sel_mode(sel_mode),
    .ext_irq(ext_irq), .running(running), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .wake_pend(wake_pend)
  );

  // R11
  reset_release_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (core_clk_en && periph_clk_en && osc_en && !wake_pend));
endmodule

// File: tb/pmc_idle_ctrl_test.sv
`timescale 1ns/1ps
module pmc_idle_ctrl_test;
  localparam int S = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        instr_valid = 1'b0;
  logic [16:0] instr_word = '0;
  logic        halt_step, ext_irq = 1'b0;
  logic        core_clk_en, periph_clk_en, osc_en, wake_pend;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pmc_idle_ctrl #(.SETTLE_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .instr_valid(instr_valid),
    .instr_word(instr_word), .halt_step(halt_step), .ext_irq(ext_irq),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .wake_pend(wake_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [31:0] gates();
    return {29'd0, core_clk_en, periph_clk_en, osc_en};
  endfunction

  task automatic io_write(input logic [7:0] a, input logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    cyc();
    io_wr = 1'b0;
  endtask

  task automatic io_read(input string req, input logic [7:0] a, input logic [15:0] exp);
    io_addr = a; io_rd = 1'b1;
    #1 chk(req, io_rdata, exp);
    io_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc();
    // R11 reset state
    chk("R11 gates in reset", gates(), 32'h7);
    chk("R11 wake_pend in reset", wake_pend, 0);
    cyc(); rst_n = 1'b1; cyc();
    chk("R11 gates after reset", gates(), 32'h7);
    io_read("R11 ictl cleared", 8'h38, 16'h0000);

    // R11 cleared depth field selects light idle
    instr_valid = 1'b1; instr_word = 17'h1FE20;
    #1 chk("R1 halt_step", halt_step, 1);
    cyc(); instr_valid = 1'b0;
    chk("R11 reset depth -> light", gates(), 32'h3);
    ext_irq = 1'b1; cyc(); ext_irq = 1'b0;
    cyc(); cyc();

    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 2; a++) begin
        logic [15:0] ictl;
        logic [31:0] exp_g;
        bit deep;
        ictl = 16'h0123 ^ 16'(s * 16'h0111) | 16'(a << 14);
        ictl[14] = a[0];
        deep = (s == 4) && (a == 1);
        exp_g = (s < 4) ? 32'h3 : (deep ? 32'h0 : 32'h1);

        io_write(8'h3D, 16'(s << 8) | 16'h00A5);
        io_write(8'h38, ictl);
        // R2 depth field is not readable
        io_read("R2 read 0x3D", 8'h3D, 16'h0000);
        // R3 interrupt-control readback
        io_read("R3 read 0x38", 8'h38, ictl);

        // R1 near-miss opcodes ignored
        for (int b = 0; b < 17; b += 4) begin
          instr_valid = 1'b1; instr_word = 17'h1FE20 ^ 17'(1 << b);
          #1 chk("R1 non-halt step", halt_step, 0);
          cyc();
          chk("R1 non-halt gates", gates(), 32'h7);
        end
        instr_valid = 1'b0;

        // R7 interrupt while running ignored
        ext_irq = 1'b1; cyc(); ext_irq = 1'b0;
        chk("R7 irq in run gates", gates(), 32'h7);
        cyc();
        chk("R7 irq in run wake", wake_pend, 0);

        // halt
        instr_valid = 1'b1; instr_word = 17'h1FE20;
        #1 chk("R1 halt_step", halt_step, 1);
        cyc(); instr_valid = 1'b0;
        chk(s < 4 ? "R4 light gates" : (deep ? "R6 deep gates" : "R5 mid gates"),
            gates(), exp_g);

        // R7 changing registers while halted does not alter mode
        io_write(8'h3D, 16'((s ^ 4) << 8));
        io_write(8'h38, ictl ^ 16'h4000);
        chk("R7 mode held", gates(), exp_g);
        chk("R7 no step while halted", halt_step, 0);
        io_write(8'h3D, 16'(s << 8));
        io_write(8'h38, ictl);

        ext_irq = 1'b1; cyc(); ext_irq = 1'b0;
        if (deep) begin
          for (int k = 0; k < S; k++) begin
            chk("R9 settle gates", gates(), 32'h1);
            chk("R10 no wake in settle", wake_pend, 0);
            cyc();
          end
          chk("R9 restored after settle", gates(), 32'h7);
        end else begin
          chk("R8 restored", gates(), 32'h7);
        end
        chk("R10 wake low first run cycle", wake_pend, 0);
        cyc();
        chk("R10 wake pulse", wake_pend, 1);
        cyc();
        chk("R10 wake single", wake_pend, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule